// File: doc/BRIEF.md
# Interrupt Entry and Run Controller

This block decides what a processor does each time an instruction finishes. It keeps the machine's run state, the program counter, an interrupt-enable flag, a saved return address and a latched interrupt-source word. When the machine is halted, a start pulse brings it into the running state. In the same step the program counter is cleared and a one-cycle pulse tells the register file to clear all of its entries. While the machine is running, each instruction boundary leads to one of three outcomes. A pending software reset request clears the program counter. If that is not the case, an enabled interrupt request is entered. If neither applies, the next instruction is fetched and the program counter advances by the instruction size.

Interrupt entry is one sequence that nothing can break into. First the current program counter and the source word are stored and the acknowledge line goes high for one cycle. The interrupt enable is cleared at that point. Next the program counter is loaded from the supplied vector address. After that the controller returns to the decision point, so the first fetch comes from the vector.

The controller is a six-state machine. ST_HALT goes to ST_START when start is asserted. ST_START always goes to ST_DECIDE. In ST_DECIDE, one of three paths is taken. A taken reset stays in ST_DECIDE. A taken interrupt goes to ST_IRQ_ACK. A fetch goes to ST_EXEC. ST_EXEC goes back to ST_DECIDE when instr_done is asserted. ST_IRQ_ACK always goes to ST_IRQ_VEC, and ST_IRQ_VEC always goes to ST_DECIDE. The machine returns to ST_HALT only through the hardware reset rst_n.

Top module: `irq_run_ctrl`

## Requirements
- R1: While rst_n is low, running, irq_en, irq_ack, fetch, gpr_clear and soft_rst_pending are 0, and pc, saved_pc and irq_info are all zero.
- R2: In ST_HALT, a start pulse sets running to 1 on the next cycle, raises gpr_clear for exactly that one cycle and leaves pc at 0. A start pulse while running changes neither running nor gpr_clear.
- R3: At a boundary with no reset taken and no interrupt taken, fetch is 1 for one cycle and pc shows the fetch address. On the following cycle pc equals that address plus 4, modulo 2^32.
- R4: An interrupt is entered only in ST_DECIDE, and only when irq_req and irq_en are both 1. A request while irq_en is 0 lets the fetch go ahead. A request in the middle of an instruction does not raise irq_ack.
- R5: When an interrupt is entered, saved_pc receives the pc value from the boundary and irq_info receives src_info. Both values are visible on the cycle after irq_ack.
- R6: irq_ack is high for exactly one cycle. From the next cycle irq_en is 0. One cycle after that, pc equals vec_addr and the next fetch is from vec_addr.
- R7: A soft_rst pulse while running sets soft_rst_pending. At the next boundary the request is taken: pc becomes 0, soft_rst_pending and irq_en become 0, and the controller makes the decision again in ST_DECIDE.
- R8: A taken reset request has priority over an enabled interrupt at the same boundary. No irq_ack is raised, and saved_pc and irq_info keep their values.
- R9: irq_en_set sets irq_en to 1 on the next cycle. If it is asserted during the irq_ack cycle, the clear wins and irq_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| start | input | 1 | Start request, acted on only while halted |
| soft_rst | input | 1 | Software reset request, latched while running |
| irq_req | input | 1 | External interrupt request level |
| irq_en_set | input | 1 | Sets the interrupt enable flag |
| instr_done | input | 1 | Current instruction has finished executing |
| src_info | input | 16 | Interrupt source information word |
| vec_addr | input | 32 | Interrupt handler address |
| running | output | 1 | Machine is in the run state |
| irq_en | output | 1 | Interrupt enable flag |
| saved_pc | output | 32 | Program counter saved on interrupt entry |
| irq_info | output | 16 | Source word latched on interrupt entry |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| pc | output | 32 | Program counter, also the fetch address |
| fetch | output | 1 | Fetch the instruction at pc this cycle |
| gpr_clear | output | 1 | Clear all general registers (start pulse) |
| soft_rst_pending | output | 1 | A reset request is waiting for a boundary |

## Verification
The assertions check several properties on every cycle. The acknowledge lasts a single cycle. The enable is clear after an acknowledge. The saved address and source word match their values at acknowledge time. fetch, irq_ack and gpr_clear are mutually exclusive. A fetch advances pc by 4. running never drops without a hardware reset. Only the bench scenarios can show the boundary-only entry rule, reset-over-interrupt priority, requests ignored while the enable is clear, the vector landing and the wrap of pc past the top of the address space. The bench runs a sweep over every combination of reset request, interrupt request and enable-set at a boundary.

// File: rtl/run_ctrl_pkg.sv
package run_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_START,
        ST_DECIDE,
        ST_EXEC,
        ST_IRQ_ACK,
        ST_IRQ_VEC
    } rc_state_e;

    typedef enum logic [1:0] {
        PC_HOLD,
        PC_ZERO,
        PC_STEP,
        PC_VEC
    } pc_sel_e;

endpackage

// File: rtl/rc_fsm.sv
module rc_fsm
    import run_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      soft_rst,
    input  logic      rst_pend,
    input  logic      irq_req,
    input  logic      irq_en,
    input  logic      instr_done,
    output rc_state_e state,
    output pc_sel_e   pc_sel,
    output logic      fetch,
    output logic      irq_ack,
    output logic      gpr_clear,
    output logic      rst_take,
    output logic      running
);

    rc_state_e state_nx;
    logic      at_boundary;
    logic      irq_take;

    assign at_boundary = (state == ST_DECIDE);
    assign rst_take    = at_boundary && (rst_pend || soft_rst);
    assign irq_take    = at_boundary && !rst_take && irq_req && irq_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:    if (start) state_nx = ST_START;
            ST_START:   state_nx = ST_DECIDE;
            ST_DECIDE: begin
                if (rst_take)      state_nx = ST_DECIDE;
                else if (irq_take) state_nx = ST_IRQ_ACK;
                else               state_nx = ST_EXEC;
            end
            ST_EXEC:    if (instr_done) state_nx = ST_DECIDE;
            ST_IRQ_ACK: state_nx = ST_IRQ_VEC;
            ST_IRQ_VEC: state_nx = ST_DECIDE;
            default:    state_nx = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        pc_sel    = PC_HOLD;
        fetch     = 1'b0;
        irq_ack   = 1'b0;
        gpr_clear = 1'b0;
        running   = 1'b1;
        unique case (state)
            ST_HALT:    running = 1'b0;
            ST_START: begin
                gpr_clear = 1'b1;
                pc_sel    = PC_ZERO;
            end
            ST_DECIDE: begin
                if (rst_take) begin
                    pc_sel = PC_ZERO;
                end else if (!irq_take) begin
                    fetch  = 1'b1;
                    pc_sel = PC_STEP;
                end
            end
            ST_EXEC:    pc_sel  = PC_HOLD;
            ST_IRQ_ACK: irq_ack = 1'b1;
            ST_IRQ_VEC: pc_sel  = PC_VEC;
            default:    running = 1'b0;
        endcase
    end

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R4
    ack_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_boundary && irq_req && irq_en && !rst_pend && !soft_rst) |=> irq_ack);

    // R8
    rst_beats_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_take |=> !irq_ack);

    // R3
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch, irq_ack, gpr_clear}));

endmodule

// File: rtl/rc_pc_unit.sv
module rc_pc_unit
    import run_ctrl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pc_sel_e           pc_sel,
    input  logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            unique case (pc_sel)
                PC_HOLD: pc <= pc;
                PC_ZERO: pc <= '0;
                PC_STEP: pc <= pc + STEP_V;
                PC_VEC:  pc <= vec_addr;
                default: pc <= pc;
            endcase
        end
    end

endmodule

// File: rtl/rc_irq_regs.sv
module rc_irq_regs #(
    parameter int ADDR_W = 32,
    parameter int INFO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              soft_rst,
    input  logic              rst_take,
    input  logic              irq_ack,
    input  logic              irq_en_set,
    input  logic [ADDR_W-1:0] pc,
    input  logic [INFO_W-1:0] src_info,
    output logic              irq_en,
    output logic              rst_pend,
    output logic [ADDR_W-1:0] saved_pc,
    output logic [INFO_W-1:0] irq_info
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (irq_ack || rst_take) begin
            irq_en <= 1'b0;
        end else if (irq_en_set) begin
            irq_en <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pend <= 1'b0;
        end else if (rst_take) begin
            rst_pend <= 1'b0;
        end else if (soft_rst && running) begin
            rst_pend <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_pc <= '0;
            irq_info <= '0;
        end else if (irq_ack) begin
            saved_pc <= pc;
            irq_info <= src_info;
        end
    end

    // R6
    ie_off_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_en);

    // R5
    save_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (saved_pc == $past(pc)));

    // R5
    save_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (irq_info == $past(src_info)));

    // R7
    pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_take |=> !rst_pend);

endmodule

// File: rtl/irq_run_ctrl.sv
module irq_run_ctrl
    import run_ctrl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INFO_W = 16,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              soft_rst,
    input  logic              irq_req,
    input  logic              irq_en_set,
    input  logic              instr_done,
    input  logic [INFO_W-1:0] src_info,
    input  logic [ADDR_W-1:0] vec_addr,
    output logic              running,
    output logic              irq_en,
    output logic [ADDR_W-1:0] saved_pc,
    output logic [INFO_W-1:0] irq_info,
    output logic              irq_ack,
    output logic [ADDR_W-1:0] pc,
    output logic              fetch,
    output logic              gpr_clear,
    output logic              soft_rst_pending
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    rc_state_e state;
    pc_sel_e   pc_sel;
    logic      rst_take;

    rc_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .soft_rst   (soft_rst),
        .rst_pend   (soft_rst_pending),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .instr_done (instr_done),
        .state      (state),
        .pc_sel     (pc_sel),
        .fetch      (fetch),
        .irq_ack    (irq_ack),
        .gpr_clear  (gpr_clear),
        .rst_take   (rst_take),
        .running    (running)
    );

    rc_pc_unit #(.ADDR_W(ADDR_W), .STEP(STEP)) pc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_sel   (pc_sel),
        .vec_addr (vec_addr),
        .pc       (pc)
    );

    rc_irq_regs #(.ADDR_W(ADDR_W), .INFO_W(INFO_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .soft_rst   (soft_rst),
        .rst_take   (rst_take),
        .irq_ack    (irq_ack),
        .irq_en_set (irq_en_set),
        .pc         (pc),
        .src_info   (src_info),
        .irq_en     (irq_en),
        .rst_pend   (soft_rst_pending),
        .saved_pc   (saved_pc),
        .irq_info   (irq_info)
    );

    // R3
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> (pc == $past(pc) + STEP_V));

    // R2
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(running));

    // R6
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IRQ_VEC) |=> (pc == $past(vec_addr)));

endmodule

// File: tb/irq_run_ctrl_tb_top.sv
module irq_run_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, start, soft_rst, irq_req, irq_en_set, instr_done;
    logic [15:0] src_info;
    logic [31:0] vec_addr;
    logic        running, irq_en, irq_ack, fetch, gpr_clear, soft_rst_pending;
    logic [31:0] saved_pc, pc;
    logic [15:0] irq_info;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] exp_pc;
    logic [31:0] exp_spc;
    logic [15:0] exp_info;
    logic        exp_ie;

    always #5 clk = ~clk;

    irq_run_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .soft_rst(soft_rst),
        .irq_req(irq_req), .irq_en_set(irq_en_set), .instr_done(instr_done),
        .src_info(src_info), .vec_addr(vec_addr), .running(running),
        .irq_en(irq_en), .saved_pc(saved_pc), .irq_info(irq_info),
        .irq_ack(irq_ack), .pc(pc), .fetch(fetch), .gpr_clear(gpr_clear),
        .soft_rst_pending(soft_rst_pending)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; start = 0; soft_rst = 0; irq_req = 0; irq_en_set = 0;
        instr_done = 0; src_info = '0; vec_addr = '0;
        tick(); tick();
        // R1 reset state
        chk("R1", "running", {31'b0, running}, 0);
        chk("R1", "irq_en", {31'b0, irq_en}, 0);
        chk("R1", "pc", pc, 0);
        chk("R1", "saved_pc", saved_pc, 0);
        chk("R1", "irq_info", {16'b0, irq_info}, 0);
        chk("R1", "strobes", {28'b0, irq_ack, fetch, gpr_clear, soft_rst_pending}, 0);
        rst_n = 1;
        tick();
        chk("R1", "halted", {31'b0, running}, 0);

        // R2 start from halt
        start = 1; tick(); start = 0;
        chk("R2", "running", {31'b0, running}, 1);
        chk("R2", "gpr_clear", {31'b0, gpr_clear}, 1);
        chk("R2", "pc", pc, 0);
        tick();
        chk("R2", "gpr_clear once", {31'b0, gpr_clear}, 0);
        chk("R3", "fetch at 0", {31'b0, fetch}, 1);
        tick();
        chk("R3", "pc step", pc, 4);
        exp_pc = 4; exp_ie = 0; exp_spc = 0; exp_info = 0;
        start = 1; tick(); start = 0;
        chk("R2", "start ignored running", {31'b0, running}, 1);
        chk("R2", "start ignored clear", {31'b0, gpr_clear}, 0);

        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int c = 0; c < 8; c++) begin
                logic b_irq, b_ie, b_rst;
                logic [31:0] vec;
                logic [15:0] inf;
                b_irq = c[0]; b_ie = c[1]; b_rst = c[2];
                vec = (rnd == 0) ? (32'h0000_2000 + 32'(c * 16)) : 32'hFFFF_FFFC;
                inf = 16'(16'hA500 + rnd * 16 + c);
                if (b_ie) begin
                    irq_en_set = 1; tick(); irq_en_set = 0;
                    exp_ie = 1;
                    chk("R9", "ie set", {31'b0, irq_en}, 1);
                end
                if (b_rst) begin
                    soft_rst = 1; tick(); soft_rst = 0;
                    chk("R7", "pending", {31'b0, soft_rst_pending}, 1);
                end
                irq_req = b_irq; src_info = inf; vec_addr = vec;
                tick();
                chk("R4", "no ack mid-instr", {31'b0, irq_ack}, 0);
                chk("R4", "pc held", pc, exp_pc);
                instr_done = 1; tick(); instr_done = 0;
                if (b_rst) begin
                    chk("R8", "no fetch on reset", {31'b0, fetch}, 0);
                    tick();
                    chk("R8", "no ack", {31'b0, irq_ack}, 0);
                    chk("R7", "pc zero", pc, 0);
                    chk("R7", "pending clr", {31'b0, soft_rst_pending}, 0);
                    chk("R7", "ie clr", {31'b0, irq_en}, 0);
                    chk("R8", "saved_pc kept", saved_pc, exp_spc);
                    exp_pc = 0; exp_ie = 0;
                end else if (b_irq && exp_ie) begin
                    chk("R4", "no fetch", {31'b0, fetch}, 0);
                    tick();
                    chk("R6", "ack high", {31'b0, irq_ack}, 1);
                    tick();
                    chk("R6", "ack one cycle", {31'b0, irq_ack}, 0);
                    chk("R6", "ie cleared", {31'b0, irq_en}, 0);
                    chk("R5", "saved_pc", saved_pc, exp_pc);
                    chk("R5", "irq_info", {16'b0, irq_info}, {16'b0, inf});
                    tick();
                    chk("R6", "pc vector", pc, vec);
                    exp_spc = exp_pc; exp_info = inf;
                    exp_pc = vec; exp_ie = 0;
                end
                chk("R3", "fetch", {31'b0, fetch}, 1);
                chk("R3", "fetch addr", pc, exp_pc);
                chk("R4", "ie model", {31'b0, irq_en}, {31'b0, exp_ie});
                tick();
                exp_pc = exp_pc + 32'd4;
                chk("R3", "pc after fetch", pc, exp_pc);
                chk("R5", "info kept", {16'b0, irq_info}, {16'b0, exp_info});
                irq_req = 0;
            end
        end

        // R9 clear wins over set during acknowledge
        irq_en_set = 1; tick(); irq_en_set = 0;
        irq_req = 1;
        instr_done = 1; tick(); instr_done = 0;
        tick();
        chk("R9", "in ack", {31'b0, irq_ack}, 1);
        irq_en_set = 1; tick(); irq_en_set = 0; irq_req = 0;
        chk("R9", "clear wins", {31'b0, irq_en}, 0);
        tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule